// File: doc/BRIEF.md
# Section Address Translation Unit

This block turns 32-bit virtual addresses into physical addresses using a one-level table of 1 MB section descriptors that sits in memory. The table has 4096 one-word entries, one per 1 MB region of the virtual space. The upper twelve bits of a virtual address select the entry directly. A client presents an address on a request port. One cycle later it gets back the physical address, the descriptor's domain number, its access permission bits and its cacheable and bufferable flags. If the descriptor is not a section, it gets a fault instead.

An eight-entry fully associative translation cache holds recent section translations, so repeated accesses to a region need no memory traffic. On a miss the unit reads one descriptor through a simple memory read port, answers the request, and caches the result if the descriptor is valid. Software may rewrite the table while translation is running. Old translations stay in use until the cache is flushed explicitly through the flush input. When translation is disabled, the unit passes addresses straight through.

Top module: `sect_xlat`

## Requirements
- R1: When `xl_en` is low, an accepted request is answered in the next cycle with `rsp_paddr` equal to the virtual address, with `rsp_fault`, `rsp_domain`, `rsp_ap`, `rsp_c` and `rsp_b` all zero, and with no memory read.
- R2: On a cache miss with translation enabled, exactly one single-cycle `mem_rd` pulse is issued, at address `{base[31:14], vaddr[31:20], 2'b00}`.
- R3: A write of the table base through `base_wr`/`base_wdata` ignores bits 13:0, so the table always starts on a 16 KB boundary.
- R4: For a descriptor with bits 1:0 equal to 2'b10 (section), the response gives `rsp_paddr = {desc[31:20], vaddr[19:0]}`, `rsp_ap = desc[11:10]`, `rsp_domain = desc[8:5]`, `rsp_c = desc[3]`, `rsp_b = desc[2]` and `rsp_fault = 0`.
- R5: A descriptor whose bits 1:0 are not 2'b10 produces a response with `rsp_fault = 1` and `rsp_paddr = 0`, and is not cached, so a repeated request walks again.
- R6: A request that hits in the translation cache is answered in the cycle after acceptance, with the cached fields and no memory read.
- R7: Edits to the table in memory do not affect a section that is already cached, until a flush.
- R8: A one-cycle `flush` pulse invalidates every cached translation, so the next request to any section walks the table.
- R9: A flush that arrives while a walk is in progress does not stop the response, but the result of that walk is not cached.
- R10: The cache holds 8 sections with round-robin replacement. After nine different sections are walked following a flush, the first one is evicted and the other eight still hit.
- R11: `req_ready` is low from the cycle after a miss is accepted until its response, and `rsp_valid` is a one-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_en | input | 1 | Translation enable; low selects pass-through |
| base_wr | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | New table base; bits 13:0 ignored |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Unit can accept a request this cycle |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 1 | Descriptor was not a section |
| rsp_domain | output | 4 | Domain number |
| rsp_ap | output | 2 | Access permission bits |
| rsp_c | output | 1 | Cacheable flag |
| rsp_b | output | 1 | Bufferable flag |
| mem_rd | output | 1 | Descriptor read request pulse |
| mem_addr | output | 32 | Descriptor address |
| mem_rvalid | input | 1 | Descriptor data valid |
| mem_rdata | input | 32 | Descriptor word |

## Verification
The assertions check the following on every cycle:
- pass-through behaviour and the absence of memory reads when translation is off;
- that a read request is a single-cycle pulse and blocks new requests;
- how a returned descriptor maps to the fault flag and the response fields;
- that an enabled request leads either to an answer in the next cycle or to a walk.

Some behaviours span several transactions, and only the bench's scenarios can show them:
- that cached translations survive a table edit;
- that a flush, including one in the middle of a walk, removes them;
- that a faulting descriptor is never cached;
- that the ninth section walked evicts the first.

// File: rtl/sx_pkg.sv
package sx_pkg;
    localparam int VA_W    = 32;
    localparam int IDX_W   = 12;
    localparam int OFS_W   = VA_W - IDX_W;
    localparam int BASE_LO = 14;

    localparam logic [1:0] DESC_SECTION = 2'b10;

    typedef struct packed {
        logic [IDX_W-1:0] pfn;
        logic [3:0]       dom;
        logic [1:0]       ap;
        logic             c;
        logic             b;
    } sect_attr_t;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2
    } wstate_t;

    function automatic sect_attr_t unpack_desc(input logic [VA_W-1:0] d);
        sect_attr_t a;
        a.pfn = d[31:20];
        a.dom = d[8:5];
        a.ap  = d[11:10];
        a.c   = d[3];
        a.b   = d[2];
        return a;
    endfunction
endpackage

// File: rtl/sx_tlb.sv
module sx_tlb
    import sx_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_tag,
    output logic             lk_hit,
    output sect_attr_t       lk_attr,
    input  logic             flush,
    input  logic             ins_en,
    input  logic [IDX_W-1:0] ins_tag,
    input  sect_attr_t       ins_attr
);
    localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PW-1:0] LAST = PW'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][IDX_W-1:0] tag;
        sect_attr_t [ENTRIES-1:0]      attr;
        logic [PW-1:0]                 ptr;
    } tlb_st_t;

    tlb_st_t st_d, st_q;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = st_q.vld[g] && (st_q.tag[g] == lk_tag);
    end

    always_comb begin
        lk_attr = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_attr = lk_attr | st_q.attr[i];
        end
        lk_hit = (|match) && !flush;
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld = '0;
        end else if (ins_en) begin
            st_d.vld[st_q.ptr]  = 1'b1;
            st_d.tag[st_q.ptr]  = ins_tag;
            st_d.attr[st_q.ptr] = ins_attr;
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sx_walk.sv
module sx_walk
    import sx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xl_en,
    input  logic [VA_W-1:BASE_LO] base,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    input  logic             hit,
    input  sect_attr_t       hit_attr,
    output logic             mem_rd,
    output logic [VA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [VA_W-1:0]  mem_rdata,
    output logic             rsp_valid,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output sect_attr_t       rsp_attr,
    output logic             ins_en,
    output logic [IDX_W-1:0] ins_tag,
    output sect_attr_t       ins_attr
);
    typedef struct packed {
        wstate_t         st;
        logic [VA_W-1:0] va;
        logic [VA_W-1:0] maddr;
        logic            kill;
        logic            rv;
        logic [VA_W-1:0] pa;
        logic            fault;
        sect_attr_t      attr;
    } walk_st_t;

    walk_st_t w_d, w_q;
    logic     is_sect;

    assign is_sect = (mem_rdata[1:0] == DESC_SECTION);

    always_comb begin
        w_d      = w_q;
        w_d.rv   = 1'b0;
        ins_en   = 1'b0;
        ins_tag  = w_q.va[VA_W-1:OFS_W];
        ins_attr = unpack_desc(mem_rdata);
        unique case (w_q.st)
            W_IDLE: begin
                if (req_valid) begin
                    w_d.va   = req_vaddr;
                    w_d.kill = 1'b0;
                    if (!xl_en) begin
                        w_d.rv    = 1'b1;
                        w_d.pa    = req_vaddr;
                        w_d.fault = 1'b0;
                        w_d.attr  = '0;
                    end else if (hit) begin
                        w_d.rv    = 1'b1;
                        w_d.pa    = {hit_attr.pfn, req_vaddr[OFS_W-1:0]};
                        w_d.fault = 1'b0;
                        w_d.attr  = hit_attr;
                    end else begin
                        w_d.st    = W_ISSUE;
                        w_d.maddr = {base, req_vaddr[VA_W-1:OFS_W], 2'b00};
                    end
                end
            end
            W_ISSUE: begin
                w_d.st = W_WAIT;
                if (flush) w_d.kill = 1'b1;
            end
            W_WAIT: begin
                if (flush) w_d.kill = 1'b1;
                if (mem_rvalid) begin
                    w_d.st    = W_IDLE;
                    w_d.rv    = 1'b1;
                    w_d.fault = !is_sect;
                    if (is_sect) begin
                        w_d.pa   = {mem_rdata[31:20], w_q.va[OFS_W-1:0]};
                        w_d.attr = unpack_desc(mem_rdata);
                    end else begin
                        w_d.pa   = '0;
                        w_d.attr = '0;
                    end
                    ins_en = is_sect && !w_q.kill && !flush;
                end
            end
            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign req_ready = (w_q.st == W_IDLE);
    assign mem_rd    = (w_q.st == W_ISSUE);
    assign mem_addr  = w_q.maddr;
    assign rsp_valid = w_q.rv;
    assign rsp_paddr = w_q.pa;
    assign rsp_fault = w_q.fault;
    assign rsp_attr  = w_q.attr;
endmodule

// File: rtl/sect_xlat.sv
module sect_xlat
    import sx_pkg::*;
#(
    parameter int TLB_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xl_en,
    input  logic        base_wr,
    input  logic [31:0] base_wdata,
    input  logic        flush,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic        rsp_fault,
    output logic [3:0]  rsp_domain,
    output logic [1:0]  rsp_ap,
    output logic        rsp_c,
    output logic        rsp_b,
    output logic        mem_rd,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata
);
    typedef struct packed {
        logic [VA_W-1:BASE_LO] base;
    } base_st_t;

    base_st_t   b_d, b_q;
    logic       hit, ins_en;
    sect_attr_t hit_attr, ins_attr, rsp_attr;
    logic [IDX_W-1:0] ins_tag;
    logic       unused_bits;

    assign unused_bits = ^{base_wdata[BASE_LO-1:0]};

    always_comb begin
        b_d = b_q;
        if (base_wr) b_d.base = base_wdata[VA_W-1:BASE_LO];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    sx_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_tag   (req_vaddr[VA_W-1:OFS_W]),
        .lk_hit   (hit),
        .lk_attr  (hit_attr),
        .flush    (flush),
        .ins_en   (ins_en),
        .ins_tag  (ins_tag),
        .ins_attr (ins_attr)
    );

    sx_walk u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .xl_en      (xl_en),
        .base       (b_q.base),
        .flush      (flush),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .req_ready  (req_ready),
        .hit        (hit),
        .hit_attr   (hit_attr),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .rsp_attr   (rsp_attr),
        .ins_en     (ins_en),
        .ins_tag    (ins_tag),
        .ins_attr   (ins_attr)
    );

    assign rsp_domain = rsp_attr.dom;
    assign rsp_ap     = rsp_attr.ap;
    assign rsp_c      = rsp_attr.c;
    assign rsp_b      = rsp_attr.b;
endmodule

// File: rtl/sx_chk.sv
module sx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xl_en,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_fault,
    input logic [3:0]  rsp_domain,
    input logic [1:0]  rsp_ap,
    input logic        mem_rd,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic [31:0] mem_rdata
);
    logic in_wait;
    assign in_wait = mem_rvalid && !req_ready && !mem_rd;

    AST_BYPASS_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xl_en) |=> (rsp_valid && !mem_rd && rsp_paddr == $past(req_vaddr))); // R1
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R2
    AST_READ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[1:0] == 2'b00)); // R3
    AST_DESC_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && mem_rdata[1:0] == 2'b10) |=> (rsp_valid && !rsp_fault
            && rsp_ap == $past(mem_rdata[11:10]) && rsp_domain == $past(mem_rdata[8:5])
            && rsp_paddr[31:20] == $past(mem_rdata[31:20]))); // R4
    AST_TYPE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && mem_rdata[1:0] != 2'b10) |=> (rsp_valid && rsp_fault && rsp_paddr == 32'h0)); // R5
    AST_HIT_OR_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && xl_en) |=> (rsp_valid || mem_rd)); // R6
    AST_BUSY_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (!req_ready && !rsp_valid)); // R11
endmodule

bind sect_xlat sx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xl_en      (xl_en),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .rsp_domain (rsp_domain),
    .rsp_ap     (rsp_ap),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata)
);

// File: tb/sim_sect_xlat.sv
`timescale 1ns/1ps
module sim_sect_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_en = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, rsp_valid, rsp_fault, rsp_c, rsp_b, mem_rd;
    logic [31:0] rsp_paddr, mem_addr;
    logic [3:0]  rsp_domain;
    logic [1:0]  rsp_ap;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    sect_xlat u0 (.*);

    localparam logic [31:0] BASE = 32'h0004_0000;

    logic [31:0] tbl [4096];
    int          rd_count = 0;
    logic [31:0] last_maddr = '0;
    bit          pend = 1'b0;
    logic [11:0] pend_idx = '0;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    // memory model: answers one negedge after it sees the read pulse
    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= tbl[pend_idx];
            pend       <= 1'b0;
        end
        if (mem_rd) begin
            rd_count   <= rd_count + 1;
            last_maddr <= mem_addr;
            pend       <= 1'b1;
            pend_idx   <= mem_addr[13:2];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] r_pa;
    logic        r_f, r_c, r_b, r_busy;
    logic [3:0]  r_dom;
    logic [1:0]  r_ap;
    int          r_nrd, r_lat;

    task automatic xact(input logic en, input logic [31:0] va, input bit flush_mid);
        int rd0;
        @(negedge clk);
        xl_en = en; req_valid = 1'b1; req_vaddr = va; rd0 = rd_count;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; r_lat = 1; r_busy = !req_ready;
        if (flush_mid) begin
            flush = 1'b1;
            @(negedge clk);
            flush = 1'b0;
            r_lat++;
        end
        while (!rsp_valid) begin
            @(negedge clk);
            r_lat++;
        end
        r_pa = rsp_paddr; r_f = rsp_fault; r_dom = rsp_domain;
        r_ap = rsp_ap; r_c = rsp_c; r_b = rsp_b;
        @(negedge clk);
        chk("R11 rsp pulse", {31'd0, rsp_valid}, 32'd0);
        r_nrd = rd_count - rd0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    // vector: en, vaddr, walks expected, fault expected, paddr expected
    typedef struct packed {
        logic        en;
        logic [31:0] va;
        logic        walk;
        logic        flt;
        logic [31:0] pa;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 32'h1234_5678, 1'b0, 1'b0, 32'h1234_5678},  // R1
        '{1'b1, 32'h1230_0010, 1'b1, 1'b0, 32'hABC0_0010},  // R2 R4
        '{1'b1, 32'h123F_FFFF, 1'b0, 1'b0, 32'hABCF_FFFF},  // R6
        '{1'b1, 32'h8000_0004, 1'b1, 1'b0, 32'h8000_0004},  // R4
        '{1'b1, 32'h7FF0_0000, 1'b1, 1'b1, 32'h0000_0000},  // R5
        '{1'b1, 32'h7FF0_0000, 1'b1, 1'b1, 32'h0000_0000},  // R5 not cached
        '{1'b1, 32'h8001_0000, 1'b0, 1'b0, 32'h8001_0000},  // R6
        '{1'b0, 32'h7FF0_0000, 1'b0, 1'b0, 32'h7FF0_0000}   // R1
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++)
            tbl[i] = {i[11:0], 8'h00, 2'b11, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0, 2'b10};
        tbl[12'h123] = {12'hABC, 8'h00, 2'b01, 1'b0, 4'h5, 1'b0, 1'b0, 1'b1, 2'b10};
        tbl[12'h7FF] = 32'h0000_0001;
        tbl[12'h7FE] = 32'h0000_0000;

        repeat (3) @(negedge clk);
        chk("R11 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R11 reset req_ready", {31'd0, req_ready}, 32'd1);
        chk("R2 reset mem_rd", {31'd0, mem_rd}, 32'd0);
        rst_n = 1'b1;

        // R3: low bits of the written base are dropped
        @(negedge clk); base_wr = 1'b1; base_wdata = BASE | 32'h0000_3ABC;
        @(negedge clk); base_wr = 1'b0;

        for (int v = 0; v < 8; v++) begin
            xact(VECS[v].en, VECS[v].va, 1'b0);
            chk($sformatf("R1/R2/R6 vec%0d reads", v), r_nrd, {31'd0, VECS[v].walk});
            chk($sformatf("R5 vec%0d fault", v), {31'd0, r_f}, {31'd0, VECS[v].flt});
            chk($sformatf("R1/R4 vec%0d paddr", v), r_pa, VECS[v].pa);
            if (VECS[v].walk) begin
                chk($sformatf("R2 R3 vec%0d mem_addr", v), last_maddr,
                    BASE | {18'd0, VECS[v].va[31:20], 2'b00});
                chk($sformatf("R11 vec%0d busy", v), {31'd0, r_busy}, 32'd1);
            end else begin
                chk($sformatf("R6 vec%0d latency", v), r_lat, 32'd1);
            end
            if (!VECS[v].en)
                chk($sformatf("R1 vec%0d attrs", v), {24'd0, r_dom, r_ap, r_c, r_b}, 32'd0);
        end

        // R4: fields of a cached section (ap=01 dom=5 c=0 b=1)
        xact(1'b1, 32'h1231_0000, 1'b0);
        chk("R4 fields", {24'd0, r_dom, r_ap, r_c, r_b}, {24'd0, 4'h5, 2'b01, 1'b0, 1'b1});
        xact(1'b1, 32'h8002_0000, 1'b0);
        chk("R4 flat fields", {24'd0, r_dom, r_ap, r_c, r_b}, {24'd0, 4'hF, 2'b11, 1'b1, 1'b0});

        // R7: table edit is invisible until flush
        tbl[12'h123] = {12'h555, 8'h00, 2'b10, 1'b0, 4'h2, 1'b0, 1'b1, 1'b1, 2'b10};
        xact(1'b1, 32'h1230_0000, 1'b0);
        chk("R7 stale paddr", r_pa, 32'hABC0_0000);
        chk("R7 stale no read", r_nrd, 32'd0);
        pulse_flush();
        xact(1'b1, 32'h1230_0000, 1'b0);
        chk("R8 after flush walks", r_nrd, 32'd1);
        chk("R8 fresh paddr", r_pa, 32'h5550_0000);
        xact(1'b1, 32'h1230_0000, 1'b0);
        chk("R8 recached", r_nrd, 32'd0);

        // R9: flush during a walk
        xact(1'b1, 32'h2000_0000, 1'b1);
        chk("R9 answered", r_pa, 32'h2000_0000);
        xact(1'b1, 32'h2000_0000, 1'b0);
        chk("R9 not cached", r_nrd, 32'd1);
        xact(1'b1, 32'h1230_0000, 1'b0);
        chk("R9 flush cleared others", r_nrd, 32'd1);

        // R10: nine sections after a flush
        pulse_flush();
        for (int s = 1; s <= 9; s++) xact(1'b1, {12'(s), 20'h0}, 1'b0);
        for (int s = 2; s <= 9; s++) begin
            xact(1'b1, {12'(s), 20'h0}, 1'b0);
            chk($sformatf("R10 section %0d hit", s), r_nrd, 32'd0);
        end
        xact(1'b1, {12'd1, 20'h0}, 1'b0);
        chk("R10 first evicted", r_nrd, 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule